// File: doc/BRIEF.md
# Clock-Synchronous Serial Port

This block moves one 8-bit character at a time over a clock-synchronous three-wire link (clock, data out, data in). As master it makes the serial clock itself by dividing the system clock by 8, 16 or 32. As slave it follows a clock from another device, after synchronizing that clock into the system clock domain. Software selects the bit order and can turn on an internal loopback, which feeds the serial output straight back into the receiver for self-test.

Software reaches the block through a small register interface with a data register, a control register and a status register. A write to the data register fills a one-byte holding buffer. The buffer moves into the shifter at once when the port is idle. When a byte is already in flight, the buffer moves in the instant that byte finishes. Each time the buffer empties in this way an event flag is set, and it can raise an interrupt line, so software can supply the next byte before the shifter runs dry.

The serial clock idles high. Data leaves on falling edges and is captured on rising edges.

Top module: `syncser_port`

## Requirements
- R1: After reset the status register (address 2) reads 0x01, the control register (address 1) reads 0x00, sck_out is 1, sck_oe is 0 and irq is 0. Address 0 is the data register.
- R2: With control bit0 (enable) = 1 and bit1 (master) = 1, sck_oe is 1. During a transfer sck_out has a period of 8, 16 or 32 system clocks for rate field bits[5:4] = 0, 1 or 2 (3 also gives 32). sck_out is 1 whenever no transfer is running.
- R3: A transfer is 8 serial clock cycles, each a low phase followed by a high phase. The first bit is presented when the byte is loaded. sdo changes only on a falling serial edge, and the receiver captures its input on each rising edge.
- R4: Control bit2 = 0 sends and assembles bit 0 first; bit2 = 1 sends and assembles bit 7 first.
- R5: With enable = 1 and master = 0, sck_oe is 0 and sck_out stays 1. Shifting follows sck_in, whose high and low phases must each last at least 4 system clocks.
- R6: Status bit1 (receive complete) is set after the eighth rising edge. Reading address 0 then returns the received byte and clears bit1.
- R7: A data write while a byte is shifting is kept in the holding buffer, and status bit0 (buffer empty) reads 0 while the buffer is occupied. The buffer enters the shifter on the eighth rising edge, so in master mode the clock period stays the same across the byte boundary. Status bit2 reads 1 while shifting.
- R8: Status bit3 is set when the holding buffer moves into the shifter. irq equals status bit3 AND control bit6. Bit3 is cleared by a data write, or by a status write with bit3 = 1.
- R9: With control bit3 (loopback) = 1 the receiver takes the port's own serial output and the sdi pin has no effect.
- R10: While enable = 0 no transfer starts and a written byte waits in the holding buffer. It is sent once enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a data read clears receive complete) |
| bus_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register |
| sck_in | input | 1 | Serial clock from a remote master (slave mode) |
| sck_out | output | 1 | Generated serial clock, idles high |
| sck_oe | output | 1 | Drive enable for sck_out (master mode) |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| irq | output | 1 | Transmit-buffer-empty interrupt |

## Verification
A wrong bit counter or pending-shift flag shows up within one byte. Either the pattern on sdo is shifted by one place, or the clock gets a ninth or seventh cycle. Either way the byte read back from address 0 and the wire pattern collected by the bench disagree at the first transfer. A broken hand-off from the holding buffer shows as a stretched clock period at the byte boundary, or as a dropped second byte in the back-to-back case. A wrong event flag shows on irq in the cycles just after the buffer empties.

// File: rtl/syncser_pkg.sv
package syncser_pkg;

   typedef enum logic [1:0] {
      ADDR_DATA = 2'd0,
      ADDR_CTRL = 2'd1,
      ADDR_STAT = 2'd2,
      ADDR_NONE = 2'd3
   } reg_addr_e;

   localparam int unsigned CTRL_W = 7;
   localparam int unsigned STAT_W = 4;

   typedef struct packed {
      logic       irq_en;     // bit 6
      logic [1:0] rate;       // bits 5:4
      logic       loopback;   // bit 3
      logic       msb_first;  // bit 2
      logic       master;     // bit 1
      logic       enable;     // bit 0
   } ctrl_t;

   localparam int unsigned STAT_EVT_BIT = 3;

endpackage

// File: rtl/syncser_clkgen.sv
module syncser_clkgen #(
   parameter int unsigned DIV_A = 8,
   parameter int unsigned DIV_B = 16,
   parameter int unsigned DIV_C = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  logic [1:0] rate,
   output logic       sck,
   output logic       fall_evt,
   output logic       rise_evt
);
   localparam int unsigned DIV_AB  = (DIV_A > DIV_B) ? DIV_A : DIV_B;
   localparam int unsigned DIV_MAX = (DIV_AB > DIV_C) ? DIV_AB : DIV_C;
   localparam int unsigned CNT_W   = $clog2(DIV_MAX / 2);

   if (DIV_A < 4 || DIV_A % 2 != 0) begin : g_bad_a
      $error("DIV_A must be even and at least 4");
   end
   if (DIV_B < 4 || DIV_B % 2 != 0) begin : g_bad_b
      $error("DIV_B must be even and at least 4");
   end
   if (DIV_C < 4 || DIV_C % 2 != 0) begin : g_bad_c
      $error("DIV_C must be even and at least 4");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] phase_last;
   logic             tick;

   always_comb begin
      case (rate)
         2'd0:    phase_last = CNT_W'(DIV_A / 2 - 1);
         2'd1:    phase_last = CNT_W'(DIV_B / 2 - 1);
         default: phase_last = CNT_W'(DIV_C / 2 - 1);
      endcase
   end

   assign tick     = active && (cnt_q == phase_last);
   assign fall_evt = tick && sck;
   assign rise_evt = tick && !sck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sck   <= 1'b1;
      end else if (!active) begin
         cnt_q <= '0;
         sck   <= 1'b1;
      end else if (tick) begin
         cnt_q <= '0;
         sck   <= ~sck;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/syncser_edgesync.sv
module syncser_edgesync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_in,
   output logic fall_evt,
   output logic rise_evt
);
   if (STAGES < 2) begin : g_bad_stages
      $error("STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b1;
            else        chain_q[i] <= sck_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b1;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign fall_evt = prev_q && !chain_q[STAGES-1];
   assign rise_evt = !prev_q && chain_q[STAGES-1];

endmodule

// File: rtl/syncser_shifter.sv
module syncser_shifter #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              msb_first,
   input  logic              fall_evt,
   input  logic              rise_evt,
   input  logic              sdi,
   input  logic              tx_avail,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              busy,
   output logic              take,
   output logic              sdo,
   output logic              done,
   output logic [DATA_W-1:0] rx_byte
);
   localparam int unsigned   CNT_W = $clog2(DATA_W);
   localparam [CNT_W-1:0]    LAST  = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] rx_q;
   logic [DATA_W-1:0] rx_next;
   logic [CNT_W-1:0]  cnt_q;
   logic              pend_q;
   logic              last_rise;

   assign last_rise = busy && rise_evt && (cnt_q == LAST);
   assign take      = en && tx_avail && (!busy || last_rise);
   assign rx_next   = msb_first ? {rx_q[DATA_W-2:0], sdi} : {sdi, rx_q[DATA_W-1:1]};
   assign sdo       = msb_first ? tx_q[DATA_W-1] : tx_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q    <= '1;
         rx_q    <= '0;
         rx_byte <= '0;
         cnt_q   <= '0;
         pend_q  <= 1'b0;
         busy    <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!en) begin
            busy   <= 1'b0;
            pend_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            if (busy && rise_evt) begin
               rx_q   <= rx_next;
               pend_q <= 1'b1;
               cnt_q  <= cnt_q + 1'b1;
               if (cnt_q == LAST) begin
                  rx_byte <= rx_next;
                  done    <= 1'b1;
                  cnt_q   <= '0;
                  pend_q  <= 1'b0;
                  busy    <= 1'b0;
               end
            end else if (busy && fall_evt && pend_q) begin
               tx_q   <= msb_first ? {tx_q[DATA_W-2:0], 1'b1} : {1'b1, tx_q[DATA_W-1:1]};
               pend_q <= 1'b0;
            end
            if (take) begin
               tx_q   <= tx_byte;
               busy   <= 1'b1;
               pend_q <= 1'b0;
               cnt_q  <= '0;
            end
         end
      end
   end

endmodule

// File: rtl/syncser_port.sv
module syncser_port
   import syncser_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DIV_A       = 8,
   parameter int unsigned DIV_B       = 16,
   parameter int unsigned DIV_C       = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_oe,
   output logic              sdo,
   input  logic              sdi,
   output logic              irq
);
   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be at least 8 to hold the control register");
   end

   ctrl_t             ctrl_q;
   logic [DATA_W-1:0] hold_q;
   logic              hold_full_q;
   logic              rx_full_q;
   logic              evt_q;

   logic data_wr, ctrl_wr, stat_wr, data_rd;
   logic m_fall, m_rise, s_fall, s_rise, fall_evt, rise_evt;
   logic clk_active, shift_in;
   logic sh_busy, sh_take, sh_done;
   logic [DATA_W-1:0] rx_byte;

   assign data_wr = bus_wr && (bus_addr == ADDR_DATA);
   assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
   assign stat_wr = bus_wr && (bus_addr == ADDR_STAT);
   assign data_rd = bus_rd && (bus_addr == ADDR_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q      <= '0;
         hold_q      <= '0;
         hold_full_q <= 1'b0;
         rx_full_q   <= 1'b0;
         evt_q       <= 1'b0;
      end else begin
         if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
         if (data_wr) hold_q <= bus_wdata;
         hold_full_q <= data_wr || (hold_full_q && !sh_take);
         if (sh_done)      rx_full_q <= 1'b1;
         else if (data_rd) rx_full_q <= 1'b0;
         if (data_wr)      evt_q <= 1'b0;
         else if (sh_take) evt_q <= 1'b1;
         else if (stat_wr && bus_wdata[STAT_EVT_BIT]) evt_q <= 1'b0;
      end
   end

   assign clk_active = sh_busy && ctrl_q.enable && ctrl_q.master;

   syncser_clkgen #(
      .DIV_A (DIV_A),
      .DIV_B (DIV_B),
      .DIV_C (DIV_C)
   ) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (clk_active),
      .rate     (ctrl_q.rate),
      .sck      (sck_out),
      .fall_evt (m_fall),
      .rise_evt (m_rise)
   );

   syncser_edgesync #(
      .STAGES (SYNC_STAGES)
   ) u_edgesync (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_in   (sck_in),
      .fall_evt (s_fall),
      .rise_evt (s_rise)
   );

   assign fall_evt = ctrl_q.master ? m_fall : s_fall;
   assign rise_evt = ctrl_q.master ? m_rise : s_rise;
   assign shift_in = ctrl_q.loopback ? sdo : sdi;

   syncser_shifter #(
      .DATA_W (DATA_W)
   ) u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (ctrl_q.enable),
      .msb_first (ctrl_q.msb_first),
      .fall_evt  (fall_evt),
      .rise_evt  (rise_evt),
      .sdi       (shift_in),
      .tx_avail  (hold_full_q),
      .tx_byte   (hold_q),
      .busy      (sh_busy),
      .take      (sh_take),
      .sdo       (sdo),
      .done      (sh_done),
      .rx_byte   (rx_byte)
   );

   assign sck_oe = ctrl_q.enable && ctrl_q.master;
   assign irq    = ctrl_q.irq_en && evt_q;

   always_comb begin
      bus_rdata = '0;
      case (reg_addr_e'(bus_addr))
         ADDR_DATA: bus_rdata = rx_byte;
         ADDR_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
         ADDR_STAT: bus_rdata[STAT_W-1:0] = {evt_q, sh_busy, rx_full_q, !hold_full_q};
         default:   bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/syncser_port_chk.sv
module syncser_port_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic take,
   input logic rise_evt,
   input logic fall_evt,
   input logic sdo,
   input logic sck_out,
   input logic done,
   input logic rx_full,
   input logic irq,
   input logic irq_en,
   input logic data_wr,
   input logic ctrl_wr,
   input logic master
);
   // R2: the generated clock rests high outside a transfer
   a_r2_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck_out);

   // R3: serial output moves only on a falling edge or a fresh load
   a_r3_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fall_evt && !take && !ctrl_wr) |=> $stable(sdo));

   // R5: in slave mode the generated clock never leaves high
   a_r5_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!master && !$past(master)) |-> sck_out);

   // R6: completion raises the receive-complete flag
   a_r6_rx_flag: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> rx_full);

   // R7: a refill during a transfer happens only on its last rising edge
   a_r7_refill_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (take && busy) |-> rise_evt);

   // R8: an emptied buffer raises the interrupt when enabled
   a_r8_irq_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (take && irq_en && !data_wr && !ctrl_wr) |=> irq);

endmodule

bind syncser_port syncser_port_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (sh_busy),
   .take     (sh_take),
   .rise_evt (rise_evt),
   .fall_evt (fall_evt),
   .sdo      (sdo),
   .sck_out  (sck_out),
   .done     (sh_done),
   .rx_full  (rx_full_q),
   .irq      (irq),
   .irq_en   (ctrl_q.irq_en),
   .data_wr  (data_wr),
   .ctrl_wr  (ctrl_wr),
   .master   (ctrl_q.master)
);

// File: tb/syncser_port_test.sv
module syncser_port_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       sck_in = 1'b1;
   logic       sck_out, sck_oe, sdo, irq;
   logic       sdi;
   logic       sdi_mon = 1'b0;
   logic       sdi_slv = 1'b0;
   logic       slave_drv = 1'b0;

   int total = 0;
   int bad   = 0;

   logic mon_bits [256];
   logic drv_bits [256];
   int   mon_per  [256];
   int   mon_n = 0;
   int   cyc = 0;
   int   last_fall = 0;
   logic prev_sck = 1'b1;

   assign sdi = slave_drv ? sdi_slv : sdi_mon;

   always #4 clk = ~clk;

   syncser_port uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .sck_in    (sck_in),
      .sck_out   (sck_out),
      .sck_oe    (sck_oe),
      .sdo       (sdo),
      .sdi       (sdi),
      .irq       (irq)
   );

   // Remote slave model: on the first low sample after a fall, grab sdo and
   // present the next bit on sdi.
   always @(negedge clk) begin
      if (prev_sck && !sck_out && mon_n < 256) begin
         mon_bits[mon_n] = sdo;
         mon_per[mon_n]  = cyc - last_fall;
         last_fall       = cyc;
         sdi_mon         = drv_bits[mon_n];
         mon_n           = mon_n + 1;
      end
      prev_sck = sck_out;
      cyc      = cyc + 1;
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      for (int i = 0; i < 3000; i++) begin
         rd(2'd2, s);
         if (!s[2] && s[0]) break;
      end
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [7:0] wire_byte(input int base, input bit msb);
      logic [7:0] b;
      for (int i = 0; i < 8; i++) begin
         if (msb) b[7-i] = mon_bits[base+i];
         else     b[i]   = mon_bits[base+i];
      end
      return b;
   endfunction

   function automatic int period_ok(input int first, input int last, input int per);
      int ok = 1;
      for (int i = first; i <= last; i++) if (mon_per[i] != per) ok = 0;
      return ok;
   endfunction

   task automatic put_drv(input int base, input logic [7:0] pat, input bit msb);
      for (int i = 0; i < 8; i++) drv_bits[base+i] = msb ? pat[7-i] : pat[i];
   endtask

   task automatic test_reset();
      logic [7:0] v;
      rd(2'd2, v); chk("R1 status", v, 8'h01);
      rd(2'd1, v); chk("R1 ctrl", v, 8'h00);
      chk("R1 sck_out", sck_out, 1);
      chk("R1 sck_oe", sck_oe, 0);
      chk("R1 irq", irq, 0);
   endtask

   task automatic test_master(input string tag, input logic [7:0] ctrl,
                              input logic [7:0] tx, input logic [7:0] pat,
                              input logic [7:0] exp_rx, input int per);
      logic [7:0] v;
      int base;
      bit msb = ctrl[2];
      wr(2'd1, ctrl);
      chk({tag, " R2 sck_oe"}, sck_oe, 1);
      base = mon_n;
      put_drv(base, pat, msb);
      wr(2'd0, tx);
      wait_idle();
      chk({tag, " R3 bit count"}, mon_n - base, 8);
      chk({tag, " R4 wire byte"}, wire_byte(base, msb), tx);
      chk({tag, " R2 period"}, period_ok(base + 1, base + 7, per), 1);
      chk({tag, " R2 idle high"}, sck_out, 1);
      rd(2'd2, v); chk({tag, " R6 rx flag set"}, v[1], 1);
      rd(2'd0, v); chk({tag, " R6 rx data"}, v, exp_rx);
      rd(2'd2, v); chk({tag, " R6 rx flag cleared"}, v[1], 0);
   endtask

   task automatic test_back_to_back();
      logic [7:0] v;
      int base;
      wr(2'd1, 8'h43);
      base = mon_n;
      put_drv(base, 8'h3C, 1'b0);
      put_drv(base + 8, 8'hD2, 1'b0);
      wr(2'd0, 8'hA5);
      repeat (3) @(negedge clk);
      chk("R8 irq after load", irq, 1);
      wr(2'd0, 8'h5A);
      chk("R8 irq cleared by write", irq, 0);
      rd(2'd2, v);
      chk("R7 buffer full", v[0], 0);
      chk("R7 busy", v[2], 1);
      wait_idle();
      chk("R7 first byte", wire_byte(base, 1'b0), 8'hA5);
      chk("R7 second byte", wire_byte(base + 8, 1'b0), 8'h5A);
      chk("R7 no gap", period_ok(base + 1, base + 15, 8), 1);
      chk("R8 irq after refill", irq, 1);
      rd(2'd0, v); chk("R6 last rx byte", v, 8'hD2);
      wr(2'd2, 8'h08);
      chk("R8 irq cleared by status", irq, 0);
   endtask

   task automatic test_slave(input string tag, input logic [7:0] ctrl,
                             input logic [7:0] tx, input logic [7:0] pat);
      logic [7:0] v, got;
      bit msb = ctrl[2];
      int quiet = 1;
      slave_drv = 1'b1;
      wr(2'd1, ctrl);
      chk({tag, " R5 sck_oe"}, sck_oe, 0);
      wr(2'd0, tx);
      repeat (4) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         sck_in = 1'b0;
         repeat (6) @(negedge clk);
         if (msb) got[7-i] = sdo; else got[i] = sdo;
         sdi_slv = msb ? pat[7-i] : pat[i];
         if (!sck_out) quiet = 0;
         repeat (2) @(negedge clk);
         sck_in = 1'b1;
         repeat (8) @(negedge clk);
      end
      chk({tag, " R5 sck_out quiet"}, quiet, 1);
      chk({tag, " R4 slave tx"}, got, tx);
      rd(2'd2, v); chk({tag, " R6 slave rx flag"}, v[1], 1);
      rd(2'd0, v); chk({tag, " R5 slave rx"}, v, pat);
      slave_drv = 1'b0;
   endtask

   task automatic test_disabled();
      logic [7:0] v;
      int base;
      wr(2'd1, 8'h02);
      base = mon_n;
      put_drv(base, 8'h81, 1'b0);
      wr(2'd0, 8'h6E);
      repeat (100) @(negedge clk);
      chk("R10 no clock while off", mon_n - base, 0);
      rd(2'd2, v);
      chk("R10 byte held", v[0], 0);
      chk("R10 not busy", v[2], 0);
      wr(2'd1, 8'h03);
      wait_idle();
      chk("R10 sent after enable", wire_byte(base, 1'b0), 8'h6E);
      rd(2'd0, v); chk("R10 rx after enable", v, 8'h81);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         drv_bits[i] = 1'b0; mon_bits[i] = 1'b0; mon_per[i] = 0;
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      test_master("lsb/8",   8'h03, 8'hB4, 8'h59, 8'h59, 8);
      test_master("msb/16",  8'h17, 8'hB4, 8'h59, 8'h59, 16);
      test_master("lsb/32",  8'h23, 8'h0F, 8'hE1, 8'hE1, 32);
      test_master("rate3",   8'h37, 8'h96, 8'h33, 8'h33, 32);
      // R9: sdi carries the inverse, receiver must still see the sent byte
      test_master("R9 loop", 8'h0F, 8'hC6, 8'h39, 8'hC6, 8);
      test_back_to_back();
      test_slave("lsb slave", 8'h01, 8'h4B, 8'hA7);
      test_slave("msb slave", 8'h05, 8'h4B, 8'hA7);
      test_disabled();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule